// File: doc/BRIEF.md
# Byte Serial Link Shifter

This block is an eight-bit serial link port. Software-side logic writes a byte into its data register and then writes the control register with the start bit set; the block then moves the byte out most significant bit first while collecting eight incoming bits into the same register. After the last bit the start bit drops and a one-cycle completion interrupt pulse is raised.

The bit clock is either generated inside the block or supplied from outside. With the internal source, each bit lasts a fixed number of tick-enable cycles: a slow period of 512 or, when the control register asks for it and the fast-mode-allowed input is high, a fast period of 16. With the external source, every strobe on the external clock input performs one shift step. The electrical link and the partner device lie outside the block.

Top module: `slink_shifter`

## Requirements
- R1: A control write (address 1) with bit 7 set while no transfer is running starts an 8-bit transfer; a control write with bit 7 clear while idle starts nothing, and no tick or strobe then changes the data register.
- R2: With control bit 0 set the internal clock is used: a bit step happens on the Nth tick_en cycle after the control write, N being 16 when control bit 1 and fast_ok are both 1 and 512 otherwise; cycles with tick_en low do not count.
- R3: With control bit 0 clear the external clock is used: tick_en has no effect and each cycle with ext_clk_stb high during a transfer is one bit step.
- R4: At each bit step the data register shifts left by one with ser_in entering bit 0; ser_out always shows data bit 7, so it carries the outgoing bit before the shift; ser_clk_pulse is high for the one cycle following each step.
- R5: After the eighth step the transfer ends: control readback bit 7 reads 0, done_irq is high for exactly one cycle, and further ticks or strobes do not change the data register.
- R6: Control readback is 0x7C OR (written value AND 0x83) when fast_ok is 1 at the write, and 0x7E OR (written value AND 0x81) when it is 0; bits 6 to 2 always read 1.
- R7: A control write during a transfer does not restart the bit count; it reselects the clock source and period and reloads the bit timer, so the next step comes a full period after that write.
- R8: After reset control reads 0x7E and data reads 0x00; with ser_in held at 1 (the idle level of an unconnected link) a transfer leaves 0xFF in the data register.
- R9: A data write (address 0) replaces the data register, and a read at address 0 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timing tick for the internal bit clock |
| fast_ok | input | 1 | Allows the fast bit period and selects the fast readback encoding |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_clk_stb | input | 1 | External clock strobe, one shift step per high cycle |
| ser_in | input | 1 | Incoming serial bit |
| ser_out | output | 1 | Outgoing serial bit (data bit 7) |
| ser_clk_pulse | output | 1 | One-cycle pulse after each bit step |
| done_irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The assertions take for granted that a register write never lands in the same cycle as a bit step, since the block then gives the write priority and skips the step, and that ext_clk_stb is only raised while the external source is selected. The stimulus honours this by issuing every write with tick_en and ext_clk_stb low and by counting tick cycles exactly, so each write falls between steps. Incoming bits are changed only between steps, which lets the bench predict the received byte bit by bit.

// File: rtl/slink_pkg.sv
package slink_pkg;

    localparam int LINK_W   = 8;
    localparam int BITCNT_W = $clog2(LINK_W + 1);

    // constant readback patterns and live-bit masks
    localparam logic [LINK_W-1:0] CTRL_FILL_STD  = 8'h7E;
    localparam logic [LINK_W-1:0] CTRL_MASK_STD  = 8'h81;
    localparam logic [LINK_W-1:0] CTRL_FILL_FAST = 8'h7C;
    localparam logic [LINK_W-1:0] CTRL_MASK_FAST = 8'h83;

    localparam int START_BIT = 7;
    localparam int SRC_BIT   = 0;
    localparam int RATE_BIT  = 1;

    typedef struct packed {
        logic [LINK_W-1:0]   data;
        logic [LINK_W-1:0]   ctrl;
        logic                busy;
        logic                internal;
        logic [BITCNT_W-1:0] bits;
        logic                irq;
        logic                pulse;
    } link_state_t;

endpackage

// File: rtl/slink_rate_sel.sv
module slink_rate_sel #(
    parameter int SLOW_PERIOD = 512,
    parameter int FAST_PERIOD = 16,
    localparam int CNT_W = $clog2(SLOW_PERIOD + 1)
) (
    input  logic             rate_req,
    input  logic             fast_ok,
    output logic [CNT_W-1:0] period
);

    always_comb begin
        if (rate_req && fast_ok) period = CNT_W'(FAST_PERIOD);
        else                     period = CNT_W'(SLOW_PERIOD);
    end

endmodule

// File: rtl/slink_bit_timer.sv
module slink_bit_timer #(
    parameter int SLOW_PERIOD = 512,
    localparam int CNT_W = $clog2(SLOW_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick_en,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        expire = 1'b0;
        if (load) begin
            t_d.cnt    = load_val;
            t_d.period = load_val;
        end else if (run && tick_en && (t_q.cnt != '0)) begin
            if (t_q.cnt == CNT_W'(1)) begin
                expire  = 1'b1;
                t_d.cnt = t_q.period;
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt    <= '0;
            t_q.period <= CNT_W'(SLOW_PERIOD);
        end else begin
            t_q <= t_d;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= t_q.period || $past(load));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (t_q.cnt == $past(load_val)));

endmodule

// File: rtl/slink_shifter.sv
module slink_shifter
    import slink_pkg::*;
#(
    parameter int SLOW_PERIOD = 512,
    parameter int FAST_PERIOD = 16,
    localparam int CNT_W = $clog2(SLOW_PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              fast_ok,
    input  logic              reg_addr,
    input  logic              reg_we,
    input  logic [LINK_W-1:0] reg_wdata,
    output logic [LINK_W-1:0] reg_rdata,
    input  logic              ext_clk_stb,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_clk_pulse,
    output logic              done_irq
);

    link_state_t s_d, s_q;

    logic             ctrl_wr, data_wr;
    logic             tmr_load, tmr_run, tmr_expire;
    logic             step;
    logic [CNT_W-1:0] sel_period;

    assign ctrl_wr = reg_we &&  reg_addr;
    assign data_wr = reg_we && !reg_addr;

    slink_rate_sel #(
        .SLOW_PERIOD(SLOW_PERIOD),
        .FAST_PERIOD(FAST_PERIOD)
    ) u_rate (
        .rate_req (reg_wdata[RATE_BIT]),
        .fast_ok  (fast_ok),
        .period   (sel_period)
    );

    assign tmr_load = ctrl_wr && reg_wdata[SRC_BIT] && (s_q.busy || reg_wdata[START_BIT]);
    assign tmr_run  = s_q.busy && s_q.internal;

    slink_bit_timer #(
        .SLOW_PERIOD(SLOW_PERIOD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (sel_period),
        .run      (tmr_run),
        .tick_en  (tick_en),
        .expire   (tmr_expire)
    );

    assign step = s_q.busy && !ctrl_wr &&
                  (s_q.internal ? tmr_expire : ext_clk_stb);

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        s_d.irq   = 1'b0;

        if (step) begin
            s_d.data  = {s_q.data[LINK_W-2:0], ser_in};
            s_d.pulse = 1'b1;
            s_d.bits  = s_q.bits - BITCNT_W'(1);
            if (s_q.bits == BITCNT_W'(1)) begin
                s_d.busy            = 1'b0;
                s_d.ctrl[START_BIT] = 1'b0;
                s_d.irq             = 1'b1;
            end
        end

        if (data_wr) s_d.data = reg_wdata;

        if (ctrl_wr) begin
            if (fast_ok) s_d.ctrl = CTRL_FILL_FAST | (reg_wdata & CTRL_MASK_FAST);
            else         s_d.ctrl = CTRL_FILL_STD  | (reg_wdata & CTRL_MASK_STD);
            if (s_q.busy || reg_wdata[START_BIT]) s_d.internal = reg_wdata[SRC_BIT];
            if (reg_wdata[START_BIT] && !s_q.busy) begin
                s_d.busy = 1'b1;
                s_d.bits = BITCNT_W'(LINK_W);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.data     <= '0;
            s_q.ctrl     <= CTRL_FILL_STD;
            s_q.busy     <= 1'b0;
            s_q.internal <= 1'b0;
            s_q.bits     <= '0;
            s_q.irq      <= 1'b0;
            s_q.pulse    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata     = reg_addr ? s_q.ctrl : s_q.data;
    assign ser_out       = s_q.data[LINK_W-1];
    assign ser_clk_pulse = s_q.pulse;
    assign done_irq      = s_q.irq;

    // R1
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(reg_we && reg_addr && reg_wdata[START_BIT]));

    // R5
    irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!s_q.busy && !s_q.ctrl[START_BIT] && ser_clk_pulse));

    // R5
    bits_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.bits != '0));

    // R3
    ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.internal && !ext_clk_stb) |=> !ser_clk_pulse);

    // R6
    ctrl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl[6:2] == 5'b11111);

    // R4
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_pulse && !$past(data_wr)) |-> (s_q.data[0] == $past(ser_in)));

endmodule

// File: tb/slink_shifter_test.sv
module slink_shifter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       fast_ok = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_clk_stb = 1'b0;
    logic       ser_in = 1'b1;
    logic       ser_out, ser_clk_pulse, done_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    slink_shifter uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .fast_ok(fast_ok),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ext_clk_stb(ext_clk_stb), .ser_in(ser_in),
        .ser_out(ser_out), .ser_clk_pulse(ser_clk_pulse), .done_irq(done_irq)
    );

    // {ctrl, fast_ok, tx byte, rx byte, ctrl readback while busy}
    localparam int NVEC = 5;
    localparam logic [40:0] VECS [NVEC] = '{
        {8'h81, 1'b0, 8'hA5, 8'h3C, 8'hFF},
        {8'h83, 1'b1, 8'h5A, 8'hC3, 8'hFF},
        {8'h83, 1'b0, 8'h12, 8'hF0, 8'hFF},
        {8'h80, 1'b0, 8'h99, 8'h66, 8'hFE},
        {8'h82, 1'b1, 8'h0F, 8'hB1, 8'hFE}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic strobe();
        ext_clk_stb = 1'b1;
        @(negedge clk);
        ext_clk_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset values
        rd(1'b1, v); check("R8 ctrl reset", v, 8'h7E);
        rd(1'b0, v); check("R8 data reset", v, 8'h00);

        // R8 unconnected link, R2 tick gating
        fast_ok = 1'b1; ser_in = 1'b1;
        wr(1'b1, 8'h83);
        ticks(8);
        repeat (30) @(negedge clk);
        ticks(7);
        rd(1'b0, v); check("R2 no step before 16 ticks", v, 8'h00);
        ticks(1);
        rd(1'b0, v); check("R2 step on 16th tick", v, 8'h01);
        ticks(112);
        rd(1'b0, v); check("R8 unconnected gives FF", v, 8'hFF);

        // R9 data register
        wr(1'b0, 8'h3C);
        rd(1'b0, v); check("R9 data readback", v, 8'h3C);

        // R6 encodings with idle writes, R1 no start
        fast_ok = 1'b1; wr(1'b1, 8'h00);
        rd(1'b1, v); check("R6 fast fill", v, 8'h7C);
        fast_ok = 1'b0; wr(1'b1, 8'h02);
        rd(1'b1, v); check("R6 std masks bit1", v, 8'h7E);
        fast_ok = 1'b1; wr(1'b1, 8'h03);
        rd(1'b1, v); check("R6 fast keeps bit1", v, 8'h7F);
        ticks(600);
        strobe();
        rd(1'b0, v); check("R1 no start without bit7", v, 8'h3C);

        // table of transfers
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] c, tx, rx, rb;
            logic f;
            int per;
            {c, f, tx, rx, rb} = VECS[k];
            per = c[0] ? ((c[1] && f) ? 16 : 512) : 0;
            fast_ok = f;
            wr(1'b0, tx);
            wr(1'b1, c);
            rd(1'b1, v); check("R1 R6 busy readback", v, rb);
            for (int b = 0; b < 8; b++) begin
                ser_in = rx[7-b];
                check("R4 ser_out", {7'd0, ser_out}, {7'd0, tx[7-b]});
                if (per != 0) begin
                    ticks(per - 1);
                    check("R2 no early pulse", {7'd0, ser_clk_pulse}, 8'd0);
                    ticks(1);
                end else begin
                    ticks(3);
                    check("R3 tick ignored", {7'd0, ser_clk_pulse}, 8'd0);
                    strobe();
                end
                check("R4 pulse", {7'd0, ser_clk_pulse}, 8'd1);
            end
            check("R5 irq", {7'd0, done_irq}, 8'd1);
            rd(1'b0, v); check("R4 rx byte", v, rx);
            rd(1'b1, v); check("R5 bit7 clear", v, rb & 8'h7F);
            @(negedge clk);
            check("R5 irq one cycle", {7'd0, done_irq}, 8'd0);
        end

        // R7 mid-transfer control write, then R5 idle after end
        fast_ok = 1'b1; ser_in = 1'b1;
        wr(1'b0, 8'hF0);
        wr(1'b1, 8'h83);
        ticks(10);
        wr(1'b1, 8'h83);
        ticks(15);
        rd(1'b0, v); check("R7 period reloaded", v, 8'hF0);
        ticks(1);
        rd(1'b0, v); check("R7 step after reload", v, 8'hE1);
        ticks(112);
        rd(1'b0, v); check("R7 count not restarted", v, 8'hFF);
        rd(1'b1, v); check("R7 ended", v, 8'h7F);
        ser_in = 1'b0;
        ticks(40);
        strobe();
        rd(1'b0, v); check("R5 no step after end", v, 8'hFF);

        finish_run();
    end

endmodule